// File: doc/BRIEF.md
# Six-Stage Pipeline Redirect and Flush Controller

This block follows every instruction in a six-stage in-order pipeline. The stages, from youngest to oldest, are fetch, decode, operand-address calculation, operand fetch, execute and result write. For each stage the block holds a valid bit, the instruction's address and a sequence tag. The fetch address and the tag of each new instruction come from the block itself. While the pipe advances, one instruction enters the fetch stage every cycle, and all stages shift together by one. Redirect inputs come from two places. The address-calculation stage reports unconditional jumps early, and only the two stages behind it are emptied. The execute stage reports taken conditional branches, and an interrupt request is resolved at the same point. Both of these empty all four younger stages.

The block chooses the fetch source and the next fetch address. It raises one kill bit per stage that is discarded, and it sends finished instructions out through a retire stream. That stream uses a valid/ready handshake: `ret_valid` is high while the write stage holds a real instruction. When `ret_ready` is low at such a time, the whole pipe freezes. Nothing is fetched or shifted, and the redirect inputs are not sampled, until the consumer accepts. An interrupt fetches from a fixed vector address. It reports a return address: the address of the oldest instruction that was discarded.

Top module: `pipe_flush_ctl`

## Requirements
- R1: While reset is asserted, `stage_valid` is all zero, `ret_valid` is 0, `fetch_src` is 0 and `fetch_addr` equals the parameter `RESET_PC`.
- R2: In every advancing cycle with no redirect, `fetch_src` is 0 (sequential). The fetch stage loads `fetch_addr`, and the next sequential address is that value plus one. Tags count up by one per fetch, modulo 2^TW. An instruction fetched at the end of cycle c retires in cycle c+6, so nine back-to-back instructions all retire by cycle 14.
- R3: The pipe advances when the write stage is empty or `ret_ready` is high. While `ret_valid` is high and `ret_ready` is low, `fetch_en` is 0 and `ret_pc`/`ret_tag` stay unchanged. In that state `stage_kill` is 0, `fetch_src` is 0, and `co_jump`, `ei_taken` and `irq_req` have no effect.
- R4: `co_jump` applies when the address-calculation stage is valid. Then `fetch_src` is 1 and `fetch_addr` equals `co_target`, and the valid instructions in the fetch and decode stages are killed.
- R5: `ei_taken` applies when the execute stage is valid. Then `fetch_src` is 2 and `fetch_addr` equals `ei_target`. Every valid instruction in the fetch through operand-fetch stages is killed, and the target is in the fetch stage in the next cycle.
- R6: `irq_req` gives `fetch_src` 3, `fetch_addr` equal to `VEC_ADDR`, and `irq_ack` 1. The fetch through operand-fetch stages are killed, and the execute-stage instruction still completes. `irq_ret_addr` is the address of the oldest valid instruction among operand fetch, address calculation, decode and fetch; if none is valid, it is the next sequential address.
- R7: Priority is interrupt, then execute-stage branch, then address-calculation jump. When an interrupt and an applied execute-stage branch come together, `irq_ret_addr` equals `ei_target`.
- R8: `co_jump` while the address-calculation stage holds a bubble, and `ei_taken` while the execute stage holds a bubble, are ignored. The fetch stays sequential and nothing is killed.
- R9: `stage_kill` bit k (bit 0 fetch, up to bit 5 write) is set only for a valid stage, and never for execute or write. A killed instruction moves on as a bubble and never retires.
- R10: `ret_valid` equals the write stage's valid bit. `ret_pc` and `ret_tag` are the address and tag of that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| co_jump | input | 1 | Unconditional jump seen in the address-calculation stage |
| co_target | input | AW | Jump destination |
| ei_taken | input | 1 | Conditional branch taken in the execute stage |
| ei_target | input | AW | Branch destination |
| irq_req | input | 1 | Interrupt request |
| fetch_en | output | 1 | Pipe advances and fetches this cycle |
| fetch_addr | output | AW | Address fetched this cycle |
| fetch_src | output | 2 | 0 sequential, 1 jump, 2 branch, 3 vector |
| stage_valid | output | 6 | Per-stage valid bits, bit 0 fetch |
| stage_kill | output | 6 | Per-stage discard strobes, bit 0 fetch |
| irq_ack | output | 1 | Interrupt taken this cycle |
| irq_ret_addr | output | AW | Resume address for the interrupt |
| ret_valid | output | 1 | Retiring instruction present |
| ret_ready | input | 1 | Consumer accepts the retiring instruction |
| ret_pc | output | AW | Address of retiring instruction |
| ret_tag | output | TW | Tag of retiring instruction |

## Verification
The assertions check the following on every cycle. A held retire beat stays stable. A frozen pipe kills nothing and never redirects. Kill strobes land only on live stages below execute, and a killed stage leaves a bubble behind it. Deep redirects empty all four younger stages. No redirect is taken from a bubble. Only the bench's scenarios can show which addresses and tags retire, and in what order, after a jump, a branch or an interrupt issued at each cycle offset from reset. The same holds for the return address chosen for each pipe fill level, for the priority between simultaneous redirects, and for a stream that continues without gaps after a stall.

// File: rtl/fc_pkg.sv
`timescale 1ns/1ps
package fc_pkg;
  localparam int NSTG  = 6;
  localparam int ST_FI = 0;
  localparam int ST_DI = 1;
  localparam int ST_CO = 2;
  localparam int ST_FO = 3;
  localparam int ST_EI = 4;
  localparam int ST_WO = 5;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_CO  = 2'd1,
    SRC_EI  = 2'd2,
    SRC_VEC = 2'd3
  } fetch_src_e;
endpackage

// File: rtl/fc_fetch_ctr.sv
`timescale 1ns/1ps
module fc_fetch_ctr #(
  parameter int AW = 16,
  parameter int TW = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] seq_pc,
  output logic [TW-1:0] next_tag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_pc   <= RESET_PC;
      next_tag <= '0;
    end else if (advance) begin
      seq_pc   <= fetch_addr + 1'b1;
      next_tag <= next_tag + 1'b1;
    end
  end
endmodule

// File: rtl/fc_stage_pipe.sv
`timescale 1ns/1ps
module fc_stage_pipe #(
  parameter int AW = 16,
  parameter int TW = 4,
  parameter int N  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  advance,
  input  logic [AW-1:0]         in_pc,
  input  logic [TW-1:0]         in_tag,
  input  logic [N-1:0]          kill,
  output logic [N-1:0]          v_q,
  output logic [N-1:0][AW-1:0]  pc_q,
  output logic [N-1:0][TW-1:0]  tag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      pc_q  <= '0;
      tag_q <= '0;
    end else if (advance) begin
      v_q[0]   <= 1'b1;
      pc_q[0]  <= in_pc;
      tag_q[0] <= in_tag;
      for (int s = 1; s < N; s++) begin
        v_q[s]   <= v_q[s-1] & ~kill[s-1];
        pc_q[s]  <= pc_q[s-1];
        tag_q[s] <= tag_q[s-1];
      end
    end
  end
endmodule

// File: rtl/fc_redirect.sv
`timescale 1ns/1ps
module fc_redirect
  import fc_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_ADDR = '0
) (
  input  logic                     advance,
  input  logic [NSTG-1:0]          stage_v,
  input  logic [NSTG-1:0][AW-1:0]  stage_pc,
  input  logic [AW-1:0]            seq_pc,
  input  logic                     co_jump,
  input  logic [AW-1:0]            co_target,
  input  logic                     ei_taken,
  input  logic [AW-1:0]            ei_target,
  input  logic                     irq_req,
  output fetch_src_e               src,
  output logic [AW-1:0]            fetch_addr,
  output logic [NSTG-1:0]          kill,
  output logic                     irq_ack,
  output logic [AW-1:0]            ret_addr
);
  localparam logic [NSTG-1:0] DEEP    = {{(NSTG-ST_EI){1'b0}}, {ST_EI{1'b1}}};
  localparam logic [NSTG-1:0] SHALLOW = {{(NSTG-ST_CO){1'b0}}, {ST_CO{1'b1}}};

  logic ei_fire, co_fire, irq_fire;

  assign ei_fire  = advance & ei_taken & stage_v[ST_EI];
  assign co_fire  = advance & co_jump  & stage_v[ST_CO];
  assign irq_fire = advance & irq_req;

  always_comb begin
    src        = SRC_SEQ;
    fetch_addr = seq_pc;
    kill       = '0;
    irq_ack    = 1'b0;
    if (irq_fire) begin
      src        = SRC_VEC;
      fetch_addr = VEC_ADDR;
      kill       = stage_v & DEEP;
      irq_ack    = 1'b1;
    end else if (ei_fire) begin
      src        = SRC_EI;
      fetch_addr = ei_target;
      kill       = stage_v & DEEP;
    end else if (co_fire) begin
      src        = SRC_CO;
      fetch_addr = co_target;
      kill       = stage_v & SHALLOW;
    end
  end

  // oldest unfinished instruction: highest valid stage below execute wins
  always_comb begin
    ret_addr = seq_pc;
    for (int s = 0; s <= ST_FO; s++) begin
      if (stage_v[s]) ret_addr = stage_pc[s];
    end
    if (ei_fire) ret_addr = ei_target;
  end
endmodule

// File: rtl/pipe_flush_ctl.sv
`timescale 1ns/1ps
module pipe_flush_ctl
  import fc_pkg::*;
#(
  parameter int AW = 16,
  parameter int TW = 4,
  parameter logic [AW-1:0] RESET_PC = 16'h0100,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFF00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          co_jump,
  input  logic [AW-1:0] co_target,
  input  logic          ei_taken,
  input  logic [AW-1:0] ei_target,
  input  logic          irq_req,
  output logic          fetch_en,
  output logic [AW-1:0] fetch_addr,
  output logic [1:0]    fetch_src,
  output logic [5:0]    stage_valid,
  output logic [5:0]    stage_kill,
  output logic          irq_ack,
  output logic [AW-1:0] irq_ret_addr,
  output logic          ret_valid,
  input  logic          ret_ready,
  output logic [AW-1:0] ret_pc,
  output logic [TW-1:0] ret_tag
);
  logic                    advance;
  logic [AW-1:0]           seq_pc;
  logic [TW-1:0]           next_tag;
  logic [NSTG-1:0]         st_v;
  logic [NSTG-1:0][AW-1:0] st_pc;
  logic [NSTG-1:0][TW-1:0] st_tag;
  logic [NSTG-1:0]         kill;
  fetch_src_e              src;
  logic [AW-1:0]           faddr;

  assign advance = ~st_v[ST_WO] | ret_ready;

  fc_fetch_ctr #(.AW(AW), .TW(TW), .RESET_PC(RESET_PC)) u_fetch (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .fetch_addr(faddr), .seq_pc(seq_pc), .next_tag(next_tag)
  );

  fc_redirect #(.AW(AW), .VEC_ADDR(VEC_ADDR)) u_redir (
    .advance(advance), .stage_v(st_v), .stage_pc(st_pc), .seq_pc(seq_pc),
    .co_jump(co_jump), .co_target(co_target),
    .ei_taken(ei_taken), .ei_target(ei_target), .irq_req(irq_req),
    .src(src), .fetch_addr(faddr), .kill(kill),
    .irq_ack(irq_ack), .ret_addr(irq_ret_addr)
  );

  fc_stage_pipe #(.AW(AW), .TW(TW), .N(NSTG)) u_pipe (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .in_pc(faddr), .in_tag(next_tag), .kill(kill),
    .v_q(st_v), .pc_q(st_pc), .tag_q(st_tag)
  );

  assign fetch_en    = advance;
  assign fetch_addr  = faddr;
  assign fetch_src   = src;
  assign stage_valid = st_v;
  assign stage_kill  = kill;
  assign ret_valid   = st_v[ST_WO];
  assign ret_pc      = st_pc[ST_WO];
  assign ret_tag     = st_tag[ST_WO];
endmodule

// File: rtl/fc_checker.sv
`timescale 1ns/1ps
module fc_checker
  import fc_pkg::*;
#(
  parameter int AW = 16,
  parameter int TW = 4,
  parameter logic [AW-1:0] VEC_ADDR = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_en,
  input logic [AW-1:0] fetch_addr,
  input logic [1:0]    fetch_src,
  input logic [5:0]    stage_valid,
  input logic [5:0]    stage_kill,
  input logic          irq_ack,
  input logic          ret_valid,
  input logic          ret_ready,
  input logic [AW-1:0] ret_pc,
  input logic [TW-1:0] ret_tag
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !ret_ready |=> ret_valid && $stable(ret_pc) && $stable(ret_tag));

  assert_frozen_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |-> stage_kill == 6'd0 && fetch_src == SRC_SEQ);

  assert_refill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |=> stage_valid[ST_FI]);

  assert_kill_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_kill & ~stage_valid) == 6'd0 && stage_kill[ST_EI] == 1'b0 && stage_kill[ST_WO] == 1'b0);

  genvar k;
  generate
    for (k = 0; k <= ST_FO; k++) begin : g_bub
      assert_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en && stage_kill[k] |=> !stage_valid[k+1]);
    end
  endgenerate

  assert_deep_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_src == SRC_EI || fetch_src == SRC_VEC) |-> stage_kill[3:0] == stage_valid[3:0]);

  assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> fetch_src == SRC_VEC && fetch_addr == VEC_ADDR);

  assert_no_bubble_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_src == SRC_EI && !stage_valid[ST_EI]) && !(fetch_src == SRC_CO && !stage_valid[ST_CO]));
endmodule

bind pipe_flush_ctl fc_checker #(.AW(AW), .TW(TW), .VEC_ADDR(VEC_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
  .fetch_src(fetch_src), .stage_valid(stage_valid), .stage_kill(stage_kill),
  .irq_ack(irq_ack), .ret_valid(ret_valid), .ret_ready(ret_ready),
  .ret_pc(ret_pc), .ret_tag(ret_tag)
);

// File: tb/tb_pipe_flush_ctl.sv
`timescale 1ns/1ps
module tb_pipe_flush_ctl;
  localparam int AW = 8;
  localparam int TW = 4;
  localparam int RST = 'h40;
  localparam int VEC = 'hE0;
  localparam int TA  = 'h90;
  localparam int TB  = 'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic co_jump = 1'b0, ei_taken = 1'b0, irq_req = 1'b0, ret_ready = 1'b1;
  logic [AW-1:0] co_target = AW'(TB);
  logic [AW-1:0] ei_target = AW'(TA);
  logic fetch_en, irq_ack, ret_valid;
  logic [AW-1:0] fetch_addr, irq_ret_addr, ret_pc;
  logic [1:0] fetch_src;
  logic [5:0] stage_valid, stage_kill;
  logic [TW-1:0] ret_tag;

  int errors = 0;
  int checks = 0;
  int ngot = 0;
  int got_pc [0:63];
  int got_tag [0:63];

  pipe_flush_ctl #(.AW(AW), .TW(TW), .RESET_PC(AW'(RST)), .VEC_ADDR(AW'(VEC))) dut (
    .clk(clk), .rst_n(rst_n), .co_jump(co_jump), .co_target(co_target),
    .ei_taken(ei_taken), .ei_target(ei_target), .irq_req(irq_req),
    .fetch_en(fetch_en), .fetch_addr(fetch_addr), .fetch_src(fetch_src),
    .stage_valid(stage_valid), .stage_kill(stage_kill), .irq_ack(irq_ack),
    .irq_ret_addr(irq_ret_addr), .ret_valid(ret_valid), .ret_ready(ret_ready),
    .ret_pc(ret_pc), .ret_tag(ret_tag)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; co_jump = 0; ei_taken = 0; irq_req = 0; ret_ready = 1;
    ngot = 0;
    repeat (2) @(posedge clk);
    #5;
    chk(stage_valid == 6'd0, "R1", "stage_valid", int'(stage_valid), 0);
    chk(ret_valid == 1'b0, "R1", "ret_valid", int'(ret_valid), 0);
    chk(fetch_src == 2'd0, "R1", "fetch_src", int'(fetch_src), 0);
    chk(int'(fetch_addr) == RST, "R1", "fetch_addr", int'(fetch_addr), RST);
    @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic sample_retire();
    if (ret_valid && ret_ready && ngot < 64) begin
      got_pc[ngot]  = int'(ret_pc);
      got_tag[ngot] = int'(ret_tag);
      ngot++;
    end
  endtask

  task automatic verify_list(input int pre, input int base, input int n, input int expcnt);
    chk(ngot == expcnt, "R9", "retire count", ngot, expcnt);
    for (int i = 0; i < ngot && i < expcnt; i++) begin
      int epc, etag;
      epc  = (i < pre) ? RST + i : base + i - pre;
      etag = (i < pre) ? i : n + i - pre;
      chk(got_pc[i] == (epc & 255), "R10", "retired pc", got_pc[i], epc & 255);
      chk(got_tag[i] == (etag & 15), "R10", "retired tag", got_tag[i], etag & 15);
    end
  endtask

  // kind: 0 none, 1 branch, 2 jump, 3 irq, 4 branch+jump, 5 irq+branch
  task automatic run_case(input int kind, input int n, input int L);
    int mask, esrc, eaddr, ekill, eret, pre, base;
    bit eack, red, eiv, cov;
    string req;
    do_reset();
    mask = (n >= 6) ? 63 : ((1 << n) - 1);
    eiv = (n >= 5);
    cov = (n >= 3);
    esrc = 0; eaddr = RST + n; ekill = 0; eack = 0; eret = 0; pre = 1000; base = 0; red = 0;
    req = "R2";
    case (kind)
      1: begin
        req = eiv ? "R5" : "R8";
        if (eiv) begin esrc = 2; eaddr = TA; ekill = mask & 15; pre = n - 4; base = TA; red = 1; end
      end
      2: begin
        req = cov ? "R4" : "R8";
        if (cov) begin esrc = 1; eaddr = TB; ekill = mask & 3; pre = n - 2; base = TB; red = 1; end
      end
      3: begin
        req = "R6";
        esrc = 3; eaddr = VEC; ekill = mask & 15; eack = 1;
        pre = (n > 4) ? n - 4 : 0; eret = RST + pre; base = VEC; red = 1;
      end
      4: begin
        req = "R7";
        esrc = 2; eaddr = TA; ekill = mask & 15; pre = n - 4; base = TA; red = 1;
      end
      default: begin
        if (kind == 5) begin
          req = "R7";
          esrc = 3; eaddr = VEC; ekill = mask & 15; eack = 1; eret = TA;
          pre = n - 4; base = VEC; red = 1;
        end
      end
    endcase
    for (int cyc = 0; cyc < L; cyc++) begin
      co_jump  = (cyc == n) && (kind == 2 || kind == 4);
      ei_taken = (cyc == n) && (kind == 1 || kind == 4 || kind == 5);
      irq_req  = (cyc == n) && (kind == 3 || kind == 5);
      #4;
      sample_retire();
      if (cyc == n) begin
        chk(int'(stage_valid) == mask, "R2", "stage_valid", int'(stage_valid), mask);
        chk(int'(fetch_src) == esrc, req, "fetch_src", int'(fetch_src), esrc);
        chk(int'(fetch_addr) == eaddr, req, "fetch_addr", int'(fetch_addr), eaddr);
        chk(int'(stage_kill) == ekill, req, "stage_kill", int'(stage_kill), ekill);
        chk(irq_ack == eack, req, "irq_ack", int'(irq_ack), int'(eack));
        if (eack) chk(int'(irq_ret_addr) == eret, req, "irq_ret_addr", int'(irq_ret_addr), eret);
      end
      @(posedge clk);
      #1;
    end
    co_jump = 0; ei_taken = 0; irq_req = 0;
    if (red) verify_list(pre, base, n, pre + ((L - n - 6) > 0 ? (L - n - 6) : 0));
    else     verify_list(1000, 0, 0, L - 6);
  endtask

  task automatic run_stall();
    do_reset();
    for (int cyc = 0; cyc < 20; cyc++) begin
      ret_ready = !(cyc >= 8 && cyc <= 10);
      ei_taken  = (cyc == 9);
      irq_req   = (cyc == 9);
      co_jump   = (cyc == 10);
      #4;
      sample_retire();
      if (cyc >= 8 && cyc <= 10) begin
        chk(fetch_en == 1'b0, "R3", "fetch_en", int'(fetch_en), 0);
        chk(stage_kill == 6'd0, "R3", "stage_kill", int'(stage_kill), 0);
        chk(fetch_src == 2'd0, "R3", "fetch_src", int'(fetch_src), 0);
        chk(irq_ack == 1'b0, "R3", "irq_ack", int'(irq_ack), 0);
        chk(ret_valid == 1'b1, "R3", "ret_valid", int'(ret_valid), 1);
        chk(int'(ret_pc) == RST + 2, "R3", "ret_pc held", int'(ret_pc), RST + 2);
      end
      if (cyc == 11) chk(int'(fetch_addr) == RST + 8, "R3", "resume fetch_addr", int'(fetch_addr), RST + 8);
      @(posedge clk);
      #1;
    end
    ret_ready = 1; ei_taken = 0; irq_req = 0; co_jump = 0;
    verify_list(1000, 0, 0, 11);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    run_case(0, 0, 15);                          // R2: nine retire by cycle 14
    for (int n = 0; n <= 9; n++) run_case(1, n, n + 12);
    for (int n = 0; n <= 7; n++) run_case(2, n, n + 12);
    for (int n = 0; n <= 8; n++) run_case(3, n, n + 12);
    for (int n = 5; n <= 7; n++) run_case(4, n, n + 12);
    for (int n = 5; n <= 7; n++) run_case(5, n, n + 12);
    run_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule